// File: doc/BRIEF.md
# Motor Drive Fault Guard

This block sits between a three-phase motor PWM generator (three upper-side and three lower-side switch drives) and the output pins. It watches two fault sources. The first is an emergency input, active low. While its watch is enabled, an active level at once forces every drive off and sets a latched emergency state. That state stays set until software clears it, and software may only clear it once the input has gone inactive.

The second source is an overload input, also active low. It passes through a sampled debounce filter. Once the filter trips, an overload state is latched. While that state is set, a programmable masking policy removes selected drives, and the PWM counter can optionally be held. The overload state clears on an explicit software request, or on a PWM synchronisation pulse or a timer pulse. Each of these clearing events is allowed only while the overload input is inactive, and the two pulse sources each have their own enable.

Software reaches the block through a small byte-wide register port with four locations: emergency control, overload control, sample-count limit, and an unlock key. The emergency watch is on after reset. The only way to switch it off is a two-byte key written to the key location.

Top module: `mfp_guard`

## Requirements
- R1: After reset the emergency control byte (address 0) reads 0x01, with the enable in bit 0 set. The overload control byte (address 1), the sample limit (address 2) and the key location (address 3) all read 0x00.
- R2: The emergency enable goes to 0 only when address 3 receives 0x5A and the very next write to address 3 is 0xA5. Any other value or order leaves it at 1. Writing 0 to bit 0 of address 0 has no effect, and writing 1 there turns the watch back on.
- R3: With the watch enabled, a low emergency input sets the emergency state on the next clock. Bit 2 of address 0 then reads 1 and all six drive outputs are 0.
- R4: Writing 1 to bit 1 of address 0 clears the emergency state only while the emergency input is high. The same write made while the input is low is ignored.
- R5: With the watch disabled, a low emergency input neither sets the emergency state nor changes the outputs.
- R6: The overload input is sampled once every 2 clocks. The overload state (bit 2 of address 1) is set when the input has been seen low on n consecutive samples, where n is address 2 bits 3:0. Settings 0 and 1 both mean one sample. A high sample restarts the count.
- R7: While the overload state is set, the mask mode in address 1 bits 5:4 selects the outputs. 00 passes every drive. 01 forces all six off. 10 forces off the drives whose bit is set in the PWM-source input.
- R8: In mask mode 11, if two or more upper drives (output bits 2:0) are on, the lower drives (bits 5:3) are forced off and the upper drives pass. Otherwise, if two or more lower drives are on, the upper drives are forced off. If neither side has two drives on, all drives pass.
- R9: The counter-stop output is high exactly while the overload state is set and address 1 bit 3 is 1.
- R10: A PWM sync pulse clears the overload state when address 1 bit 6 is 1, and a timer pulse clears it when bit 7 is 1. In both cases the overload input must be high, and with the enable bit at 0 the pulse has no effect.
- R11: Writing 1 to bit 1 of address 1 clears the overload state only while the overload input is high.
- R12: The return bits (bit 1 of addresses 0 and 1) and the key location always read back as 0.
- R13: While the emergency state is set, all outputs are 0 regardless of overload state or mask mode.
- R14: With the overload enable (address 1 bit 0) at 0, the overload input never sets the overload state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| emg_n | input | 1 | Emergency input, active low |
| ovl_n | input | 1 | Overload input, active low |
| pwm_sync | input | 1 | PWM synchronisation pulse |
| tmr1_pulse | input | 1 | Timer pulse |
| pwm_in | input | 6 | Drive requests: bits 2:0 upper, bits 5:3 lower |
| pwm_sel | input | 6 | Marks drives currently sourced by PWM |
| pins_o | output | 6 | Gated drive outputs, 1 = on |
| cnt_stop_o | output | 1 | Hold request for the PWM counter |

## Verification
The bench probes the key sequence with a reversed order and with a broken pair. A design that only looked for 0xA5, or that kept its armed flag across a foreign byte, would drop the emergency watch there. The return bits are tried while each fault input is still active; a missing guard shows up as a state that clears too early. The filter is timed with a limit of 4, at the last cycle before the trip and the first cycle by which it must have happened, then driven with an alternating input that must never trip, and given limits 0, 1 and 2 to catch a design that reads 0 as sixteen samples or as none. In mode 11 the vectors cover each side winning, neither side winning, and both sides full; a wrong priority or a wrong side index gives the wrong half of the outputs.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_EMG = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_OVL = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LIM = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_KEY = 2'd3;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h5A;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hA5;

  typedef enum logic [1:0] {
    MASK_NONE = 2'b00,
    MASK_ALL  = 2'b01,
    MASK_PWM  = 2'b10,
    MASK_SIDE = 2'b11
  } mask_mode_e;

  typedef struct packed {
    logic       tmr_ret_en;
    logic       sync_ret_en;
    mask_mode_e mode;
    logic       stop_en;
    logic       ovl_en;
  } ovl_cfg_t;
endpackage

// File: rtl/mfp_regs.sv
`timescale 1ns/1ps
module mfp_regs
  import mfp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              emg_state_i,
  input  logic              ovl_state_i,
  output logic              emg_en_o,
  output ovl_cfg_t          cfg_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              emg_ret_o,
  output logic              ovl_ret_o
);
  logic wr_emg, wr_ovl, wr_lim, wr_key;
  logic emg_en_q, emg_en_d;
  logic armed_q, armed_d;
  ovl_cfg_t cfg_q, cfg_d;
  logic [CNT_W-1:0] lim_q, lim_d;

  assign wr_emg = bus_wr && (bus_addr == ADR_EMG);
  assign wr_ovl = bus_wr && (bus_addr == ADR_OVL);
  assign wr_lim = bus_wr && (bus_addr == ADR_LIM);
  assign wr_key = bus_wr && (bus_addr == ADR_KEY);

  always_comb begin
    emg_en_d = emg_en_q;
    armed_d  = armed_q;
    cfg_d    = cfg_q;
    lim_d    = lim_q;
    if (wr_emg && bus_wdata[0]) emg_en_d = 1'b1;
    if (wr_key) begin
      if (armed_q && (bus_wdata == KEY_FIRE)) begin
        emg_en_d = 1'b0;
        armed_d  = 1'b0;
      end else begin
        armed_d = (bus_wdata == KEY_ARM);
      end
    end
    if (wr_ovl) begin
      cfg_d.tmr_ret_en  = bus_wdata[7];
      cfg_d.sync_ret_en = bus_wdata[6];
      cfg_d.mode        = mask_mode_e'(bus_wdata[5:4]);
      cfg_d.stop_en     = bus_wdata[3];
      cfg_d.ovl_en      = bus_wdata[0];
    end
    if (wr_lim) lim_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emg_en_q <= 1'b1;
      armed_q  <= 1'b0;
      cfg_q    <= '0;
      lim_q    <= '0;
    end else begin
      emg_en_q <= emg_en_d;
      armed_q  <= armed_d;
      cfg_q    <= cfg_d;
      lim_q    <= lim_d;
    end
  end

  assign emg_ret_o = wr_emg && bus_wdata[1];
  assign ovl_ret_o = wr_ovl && bus_wdata[1];
  assign emg_en_o  = emg_en_q;
  assign cfg_o     = cfg_q;
  assign lim_o     = lim_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_EMG: begin
        bus_rdata[0] = emg_en_q;
        bus_rdata[2] = emg_state_i;
      end
      ADR_OVL: begin
        bus_rdata[0]   = cfg_q.ovl_en;
        bus_rdata[2]   = ovl_state_i;
        bus_rdata[3]   = cfg_q.stop_en;
        bus_rdata[5:4] = cfg_q.mode;
        bus_rdata[6]   = cfg_q.sync_ret_en;
        bus_rdata[7]   = cfg_q.tmr_ret_en;
      end
      ADR_LIM: bus_rdata[CNT_W-1:0] = lim_q;
      default: bus_rdata = '0;
    endcase
  end

  // R2: the watch can only drop right after the closing key byte
  p_key_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(emg_en_q) |-> $past(wr_key && (bus_wdata == KEY_FIRE)));
endmodule

// File: rtl/mfp_ovl_filter.sv
`timescale 1ns/1ps
module mfp_ovl_filter #(
  parameter int CNT_W      = 4,
  parameter int SAMPLE_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             clr_req_i,
  output logic             state_o
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = '1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] need;
  logic             state_q, state_d;
  logic             tick, hit;

  assign tick = (div_q == DIV_LAST);
  assign need = (lim_i <= CNT_W'(1)) ? CNT_W'(1) : lim_i;
  assign hit  = tick && active_i &&
                (({1'b0, run_q} + (CNT_W+1)'(1)) >= {1'b0, need});

  always_comb begin
    div_d   = tick ? '0 : div_q + DIV_W'(1);
    run_d   = run_q;
    state_d = state_q;
    if (tick) begin
      if (!active_i)            run_d = '0;
      else if (run_q != RUN_MAX) run_d = run_q + CNT_W'(1);
    end
    if (enable_i && hit)            state_d = 1'b1;
    else if (clr_req_i && !active_i) state_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      run_q   <= '0;
      state_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      run_q   <= run_d;
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  // R6: a trip only follows an active sample
  p_trip_needs_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q) |-> $past(active_i));
  // R10 / R11: no clearing while the input is still active
  p_hold_while_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q && active_i) |=> state_q);
  // R14: disabled filter never trips
  p_no_trip_disabled_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_q && !enable_i) |=> !state_q);
endmodule

// File: rtl/mfp_phase_mask.sv
`timescale 1ns/1ps
module mfp_phase_mask
  import mfp_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NPH-1:0]  pwm_i,
  input  logic [2*NPH-1:0]  sel_i,
  input  mask_mode_e        mode_i,
  input  logic              ovl_state_i,
  input  logic              emg_state_i,
  output logic [2*NPH-1:0]  pins_o
);
  localparam int NOUT = 2 * NPH;

  logic [NPH-1:0]  up_on, lo_on;
  logic            up_many, lo_many;
  logic [NOUT-1:0] masked;

  assign up_on   = pwm_i[NPH-1:0];
  assign lo_on   = pwm_i[NOUT-1:NPH];
  assign up_many = ($countones(up_on) >= 2);
  assign lo_many = ($countones(lo_on) >= 2);

  always_comb begin
    masked = pwm_i;
    if (ovl_state_i) begin
      case (mode_i)
        MASK_NONE: masked = pwm_i;
        MASK_ALL:  masked = '0;
        MASK_PWM:  masked = pwm_i & ~sel_i;
        MASK_SIDE: begin
          if (up_many)      masked = {{NPH{1'b0}}, up_on};
          else if (lo_many) masked = {lo_on, {NPH{1'b0}}};
        end
        default:   masked = pwm_i;
      endcase
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_gate
    assign pins_o[g] = masked[g] && !emg_state_i;
  end

  // R8: upper side wins, lower drives are dropped
  p_side_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_state_i && (mode_i == MASK_SIDE) && up_many) |-> (pins_o[NOUT-1:NPH] == '0));
  // R7: mode 01 leaves nothing on
  p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_state_i && (mode_i == MASK_ALL)) |-> (pins_o == '0));
endmodule

// File: rtl/mfp_guard.sv
`timescale 1ns/1ps
module mfp_guard
  import mfp_pkg::*;
#(
  parameter int NPH        = 3,
  parameter int CNT_W      = 4,
  parameter int SAMPLE_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              emg_n,
  input  logic              ovl_n,
  input  logic              pwm_sync,
  input  logic              tmr1_pulse,
  input  logic [2*NPH-1:0]  pwm_in,
  input  logic [2*NPH-1:0]  pwm_sel,
  output logic [2*NPH-1:0]  pins_o,
  output logic              cnt_stop_o
);
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic             emg_en, emg_ret, ovl_ret;
  ovl_cfg_t         cfg;
  logic [CNT_W-1:0] lim;
  logic             emg_state_q, emg_state_d;
  logic             ovl_state;
  logic             emg_active, ovl_active, ovl_clr;

  assign emg_active = !emg_n;
  assign ovl_active = !ovl_n;

  mfp_regs #(.CNT_W(CNT_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .emg_state_i (emg_state_q),
    .ovl_state_i (ovl_state),
    .emg_en_o    (emg_en),
    .cfg_o       (cfg),
    .lim_o       (lim),
    .emg_ret_o   (emg_ret),
    .ovl_ret_o   (ovl_ret)
  );

  always_comb begin
    emg_state_d = emg_state_q;
    if (emg_en && emg_active)       emg_state_d = 1'b1;
    else if (emg_ret && !emg_active) emg_state_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) emg_state_q <= 1'b0;
    else          emg_state_q <= emg_state_d;
  end

  assign ovl_clr = ovl_ret || (cfg.sync_ret_en && pwm_sync) ||
                   (cfg.tmr_ret_en && tmr1_pulse);

  mfp_ovl_filter #(.CNT_W(CNT_W), .SAMPLE_DIV(SAMPLE_DIV)) filt_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .active_i  (ovl_active),
    .enable_i  (cfg.ovl_en),
    .lim_i     (lim),
    .clr_req_i (ovl_clr),
    .state_o   (ovl_state)
  );

  mfp_phase_mask #(.NPH(NPH)) mask_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .pwm_i       (pwm_in),
    .sel_i       (pwm_sel),
    .mode_i      (cfg.mode),
    .ovl_state_i (ovl_state),
    .emg_state_i (emg_state_q),
    .pins_o      (pins_o)
  );

  assign cnt_stop_o = ovl_state && cfg.stop_en;

  // R3: an enabled emergency input blanks the drives one clock later
  p_emg_blank_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (emg_en && emg_active) |=> (pins_o == '0));
  // R4: no return while the emergency input is held
  p_emg_hold_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (emg_state_q && emg_active) |=> emg_state_q);
  // R5: with the watch off, the state cannot be entered
  p_emg_off_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!emg_state_q && !emg_en) |=> !emg_state_q);
endmodule

// File: tb/mfp_guard_tb_top.sv
`timescale 1ns/1ps
module mfp_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       emg_n, ovl_n, pwm_sync, tmr1_pulse;
  logic [5:0] pwm_in, pwm_sel, pins_o;
  logic       cnt_stop_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .emg_n(emg_n),
    .ovl_n(ovl_n), .pwm_sync(pwm_sync), .tmr1_pulse(tmr1_pulse),
    .pwm_in(pwm_in), .pwm_sel(pwm_sel), .pins_o(pins_o),
    .cnt_stop_o(cnt_stop_o)
  );

  // {mode[1:0], pwm[5:0], sel[5:0], expected[5:0]}  (R7, R8)
  localparam logic [19:0] VEC [8] = '{
    {2'b00, 6'h15, 6'h00, 6'h15},
    {2'b01, 6'h3F, 6'h00, 6'h00},
    {2'b10, 6'h3F, 6'h09, 6'h36},
    {2'b10, 6'h12, 6'h30, 6'h02},
    {2'b11, 6'h0B, 6'h00, 6'h03},
    {2'b11, 6'h31, 6'h00, 6'h30},
    {2'b11, 6'h09, 6'h00, 6'h09},
    {2'b11, 6'h3F, 6'h00, 6'h07}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trip_ovl(); // limit already 0 or 1
    ovl_n = 1'b0;
    cyc(3);
  endtask

  task automatic pulse_sync();
    @(negedge clk); pwm_sync = 1'b1;
    @(negedge clk); pwm_sync = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr1_pulse = 1'b1;
    @(negedge clk); tmr1_pulse = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    emg_n = 1'b1; ovl_n = 1'b1; pwm_sync = 1'b0; tmr1_pulse = 1'b0;
    pwm_in = 6'h3F; pwm_sel = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    peek(2'd0, 8'h01, "R1 emg ctrl");
    peek(2'd1, 8'h00, "R1 ovl ctrl");
    peek(2'd2, 8'h00, "R1 limit");
    peek(2'd3, 8'h00, "R1 key");
    chk("R1 pins pass", {2'b0, pins_o}, 8'h3F);
    chk("R1 cnt_stop", {7'b0, cnt_stop_o}, 8'h00);

    // Mask table walk (R7, R8)
    wr(2'd1, 8'h01);
    trip_ovl();
    ovl_n = 1'b1;
    peek(2'd1, 8'h05, "R6 trip at limit 0");
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {2'b00, VEC[i][19:18], 4'b0001});
      pwm_in  = VEC[i][17:12];
      pwm_sel = VEC[i][11:6];
      #1;
      chk($sformatf("R7/R8 vector %0d", i), {2'b0, pins_o}, {2'b0, VEC[i][5:0]});
    end
    pwm_in = 6'h3F; pwm_sel = '0;

    // R9 counter stop
    wr(2'd1, 8'h09);
    #1 chk("R9 stop active", {7'b0, cnt_stop_o}, 8'h01);
    wr(2'd1, 8'h0B);
    #1 chk("R9 stop released", {7'b0, cnt_stop_o}, 8'h00);
    peek(2'd1, 8'h09, "R11 return clears, R12 ret reads 0");

    // R11 return ignored while input active
    wr(2'd1, 8'h01);
    trip_ovl();
    wr(2'd1, 8'h03);
    peek(2'd1, 8'h05, "R11 return while active");
    ovl_n = 1'b1;
    wr(2'd1, 8'h03);
    peek(2'd1, 8'h01, "R11 return when inactive");

    // R10 automatic return
    wr(2'd1, 8'hC1);
    trip_ovl();
    pulse_sync();
    pulse_tmr();
    peek(2'd1, 8'hC5, "R10 pulses while active");
    ovl_n = 1'b1;
    wr(2'd1, 8'h01);
    pulse_sync();
    pulse_tmr();
    peek(2'd1, 8'h05, "R10 pulses with enables off");
    wr(2'd1, 8'h41);
    pulse_tmr();
    peek(2'd1, 8'h45, "R10 timer with only sync enabled");
    pulse_sync();
    peek(2'd1, 8'h41, "R10 sync return");
    wr(2'd1, 8'h81);
    cyc(2);
    trip_ovl();
    ovl_n = 1'b1;
    cyc(1);
    peek(2'd1, 8'h85, "R10 tripped again");
    pulse_tmr();
    peek(2'd1, 8'h81, "R10 timer return");

    // R14 disabled overload
    wr(2'd1, 8'h00);
    ovl_n = 1'b0;
    cyc(8);
    peek(2'd1, 8'h00, "R14 no trip when disabled");
    ovl_n = 1'b1;
    cyc(3);

    // R6 timing with limit 4
    wr(2'd2, 8'h04);
    peek(2'd2, 8'h04, "R6 limit readback");
    wr(2'd1, 8'h01);
    cyc(2);
    ovl_n = 1'b0;
    cyc(5);
    peek(2'd1, 8'h01, "R6 not yet at 5 clocks");
    cyc(4);
    peek(2'd1, 8'h05, "R6 tripped by 9 clocks");
    ovl_n = 1'b1;
    wr(2'd1, 8'h03);
    cyc(3);

    // R6 non-consecutive samples with limit 3
    wr(2'd2, 8'h03);
    for (int k = 0; k < 5; k++) begin
      ovl_n = 1'b0; cyc(2);
      ovl_n = 1'b1; cyc(2);
    end
    peek(2'd1, 8'h01, "R6 broken run never trips");

    // R6 limits 0, 1, 2
    wr(2'd2, 8'h01);
    cyc(2);
    ovl_n = 1'b0; cyc(2);
    peek(2'd1, 8'h05, "R6 limit 1 one sample");
    ovl_n = 1'b1; wr(2'd1, 8'h03); cyc(3);
    wr(2'd2, 8'h00);
    cyc(2);
    ovl_n = 1'b0; cyc(2);
    peek(2'd1, 8'h05, "R6 limit 0 one sample");
    ovl_n = 1'b1; wr(2'd1, 8'h03); cyc(3);
    wr(2'd2, 8'h02);
    cyc(2);
    ovl_n = 1'b0; cyc(2);
    peek(2'd1, 8'h01, "R6 limit 2 needs two samples");
    cyc(3);
    peek(2'd1, 8'h05, "R6 limit 2 trips");
    ovl_n = 1'b1; wr(2'd1, 8'h03); cyc(3);

    // R3 / R4 emergency
    pwm_in = 6'h3F;
    @(negedge clk); emg_n = 1'b0;
    @(negedge clk);
    chk("R3 pins off", {2'b0, pins_o}, 8'h00);
    peek(2'd0, 8'h05, "R3 emg status");
    wr(2'd0, 8'h03);
    peek(2'd0, 8'h05, "R4 return while low");
    emg_n = 1'b1;
    cyc(1);
    chk("R4 pins still off", {2'b0, pins_o}, 8'h00);
    wr(2'd0, 8'h03);
    peek(2'd0, 8'h01, "R4 return, R12 ret bit reads 0");
    #1 chk("R4 pins restored", {2'b0, pins_o}, 8'h3F);

    // R13 priority over overload mode 00
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h01);
    trip_ovl();
    ovl_n = 1'b1;
    emg_n = 1'b0;
    @(negedge clk);
    chk("R13 emg beats mask none", {2'b0, pins_o}, 8'h00);
    emg_n = 1'b1;
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h03);
    #1 chk("R13 both cleared", {2'b0, pins_o}, 8'h3F);

    // R2 key sequence
    wr(2'd3, 8'hA5);
    wr(2'd3, 8'h5A);
    wr(2'd3, 8'h00);
    wr(2'd3, 8'hA5);
    peek(2'd0, 8'h01, "R2 wrong order keeps enable");
    wr(2'd0, 8'h00);
    peek(2'd0, 8'h01, "R2 zero write no effect");
    peek(2'd3, 8'h00, "R12 key reads 0");
    wr(2'd3, 8'h5A);
    wr(2'd3, 8'hA5);
    peek(2'd0, 8'h00, "R2 key disables");

    // R5 disabled watch
    emg_n = 1'b0;
    cyc(3);
    chk("R5 pins unaffected", {2'b0, pins_o}, 8'h3F);
    peek(2'd0, 8'h00, "R5 no emg state");
    emg_n = 1'b1;
    cyc(1);
    wr(2'd0, 8'h01);
    peek(2'd0, 8'h01, "R2 re-enable");

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule